// File: doc/BRIEF.md
# Line-tripling framebuffer scan-out engine

This block produces the timing for a 625-line display frame and streams 8-bit pixel bytes from a frame buffer that is organised by rows. A horizontal counter sets the length of a scanline in system-clock ticks and drives hsync. A vertical counter advances once per scanline and drives vsync. Partway through each scanline, a burst reads one buffer row byte by byte and drives the bytes onto a parallel pixel bus. Each byte is held for a fixed number of ticks. Each buffer row appears on three consecutive scanlines, so a buffer of VSIZE rows fills roughly three times as many display lines.

Bursts start only after the frame has passed its sync and back-porch lines. The row sequencer keeps a logical row index apart from the physical read pointer. When the index reaches the middle of the buffer, the pointer jumps to the lower half. When the index reaches the end, the pointer returns to row 0. At each of these two points the block flips the top-drawing and bottom-drawing flags and pulses process-ready. Software can then redraw the half of the buffer that is not being read.

The buffer read port is plain and has a fixed latency. The block issues a read and expects the byte one cycle later. The port has no valid/ready handshake and no back-pressure, because the pixel cadence cannot stall. All line, frame and burst timings are parameters.

Top module: `tri_line_scanout`

## Requirements
- R1: hsync is high while the horizontal tick count within a line is below HSYNC_TICKS, and low otherwise. A line lasts LINE_TICKS ticks, and tick 0 is the first cycle after reset.
- R2: The line count advances when each line ends and wraps after FRAME_LINES lines. vsync is high during lines 0 to VSYNC_LINES-1.
- R3: A frame-valid flag is set at the start of line ACTIVE_LINE. It is cleared when the row index completes its wrap (see R8). No buffer read occurs while the flag is clear.
- R4: When frame-valid is set, a burst is triggered in the cycle whose tick equals BURST_START. In that trigger cycle T, the block issues a read of byte address 0 (rd_en high). It issues a read of byte address k in cycle T+k*BYTE_TICKS, for k from 0 to HSIZE+1. No other reads are issued.
- R5: Byte k of the burst row drives the pixel bus from cycle T+2+k*BYTE_TICKS for BYTE_TICKS cycles. Outside that span the pixel bus is 0.
- R6: rd_row stays constant for three consecutive bursts and changes only in the cycle after a burst ends. Except at the jumps in R7 and R8, the row pointer then advances by one.
- R7: After three bursts, if the row index becomes VSIZE/2-1, the pointer jumps to row VSIZE/2, so buffer row VSIZE/2-1 is never read. In the cycle after that burst's final tick (cycle T+BYTE_TICKS*(HSIZE+2)+1), bottom-drawing becomes 1, top-drawing becomes 0 and process-ready is high.
- R8: After three bursts, if the row index becomes VSIZE-1, the index, the repeat count and frame-valid are all cleared, and the pointer returns to row 0. In that same following cycle, top-drawing becomes 1, bottom-drawing becomes 0 and process-ready is high. Each frame therefore contains exactly 3*(VSIZE-1) bursts.
- R9: During reset and right after it, the outputs are as follows: hsync and vsync high, pixel 0, rd_en low, top-drawing 1, bottom-drawing 0 and process-ready 0.
- R10: process-ready is high for exactly one cycle, and only at the two events of R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | output | 1 | Buffer read strobe; data is expected one cycle later |
| rd_row | output | clog2(VSIZE) | Buffer row address |
| rd_byte | output | clog2(HSIZE+2) | Byte address within the row |
| rd_data | input | 8 | Byte returned by the buffer one cycle after rd_en |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| pixel | output | 8 | Pixel byte bus |
| top_drawing | output | 1 | Upper half of the buffer is being read |
| bot_drawing | output | 1 | Lower half of the buffer is being read |
| proc_ready | output | 1 | One-cycle pulse when the read half changes |

## Verification
The assertions assume that the parameters are consistent. A burst of BYTE_TICKS*(HSIZE+2)+2 ticks starting at BURST_START must fit inside one line. Frame-valid may therefore drop only after the last read of a burst, and process-ready can never occur in two adjacent cycles. The assertions also assume that rd_data holds the addressed byte exactly one cycle after rd_en, with no stall. The bench buffer model answers every read on the next clock edge. The bench parameters are shrunk so that each burst ends well before the line wraps, and all 3*(VSIZE-1) bursts of a frame finish before the frame's last line.

// File: rtl/tls_pkg.sv
package tls_pkg;

  typedef enum logic {
    HALF_TOP = 1'b0,
    HALF_BOT = 1'b1
  } half_e;

  // Counter width that is never zero.
  function automatic int unsigned cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tls_timing.sv
module tls_timing import tls_pkg::*; #(
  parameter int unsigned LINE_TICKS  = 4096,
  parameter int unsigned HSYNC_TICKS = 288,
  parameter int unsigned BURST_START = 800,
  parameter int unsigned FRAME_LINES = 625,
  parameter int unsigned VSYNC_LINES = 2,
  parameter int unsigned ACTIVE_LINE = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic hsync,
  output logic vsync,
  output logic burst_slot,
  output logic window_open
);
  localparam int unsigned HW = cw(LINE_TICKS);
  localparam int unsigned VW = cw(FRAME_LINES);
  localparam int unsigned OPEN_PREV = (ACTIVE_LINE == 0) ? FRAME_LINES - 1 : ACTIVE_LINE - 1;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_end;

  assign line_end = (hcnt == HW'(LINE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + 1'b1;
      if (line_end)
        vcnt <= (vcnt == VW'(FRAME_LINES - 1)) ? '0 : vcnt + 1'b1;
    end
  end

  assign hsync       = (hcnt < HW'(HSYNC_TICKS));
  assign vsync       = (vcnt < VW'(VSYNC_LINES));
  assign burst_slot  = (hcnt == HW'(BURST_START));
  assign window_open = line_end && (vcnt == VW'(OPEN_PREV));

  AST_HSYNC_RISE_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (hcnt == '0)); // R1
  AST_VSYNC_MOVES_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> (hcnt == '0)); // R2

endmodule

// File: rtl/tls_burst.sv
module tls_burst import tls_pkg::*; #(
  parameter int unsigned HSIZE      = 50,
  parameter int unsigned BYTE_TICKS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      burst_slot,
  input  logic                      frame_valid,
  input  logic [7:0]                rd_data,
  output logic                      rd_en,
  output logic [cw(HSIZE+2)-1:0]    rd_byte,
  output logic [7:0]                pixel,
  output logic                      burst_done
);
  localparam int unsigned NBYTES = HSIZE + 2;
  localparam int unsigned BW     = cw(NBYTES);
  localparam int unsigned SW     = cw(BYTE_TICKS);

  logic          busy;
  logic [SW-1:0] sub;
  logic [BW-1:0] idx;
  logic          data_valid;
  logic          trig, last_sub, last_byte, step_read;

  assign trig      = burst_slot && frame_valid && !busy;
  assign last_sub  = (sub == SW'(BYTE_TICKS - 1));
  assign last_byte = (idx == BW'(NBYTES - 1));
  assign step_read = busy && last_sub && !last_byte;
  assign burst_done = busy && last_sub && last_byte;

  // Each read goes out one cycle ahead of the byte slot it feeds.
  assign rd_en   = trig || step_read;
  assign rd_byte = trig ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sub  <= '0;
      idx  <= '0;
    end else if (trig) begin
      busy <= 1'b1;
      sub  <= '0;
      idx  <= '0;
    end else if (busy) begin
      if (last_sub) begin
        sub <= '0;
        if (last_byte) busy <= 1'b0;
        else           idx  <= idx + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_valid <= 1'b0;
      pixel      <= '0;
    end else begin
      data_valid <= rd_en;
      if (data_valid)  pixel <= rd_data;
      else if (!busy)  pixel <= '0;
    end
  end

  AST_READ_NEEDS_VALID_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> frame_valid); // R3
  AST_PIXEL_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (pixel == 8'h00)); // R5

endmodule

// File: rtl/tls_rows.sv
module tls_rows import tls_pkg::*; #(
  parameter int unsigned VSIZE   = 200,
  parameter int unsigned REPEATS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   window_open,
  input  logic                   burst_done,
  output logic                   frame_valid,
  output logic [cw(VSIZE)-1:0]   rd_row,
  output logic                   top_drawing,
  output logic                   bot_drawing,
  output logic                   proc_ready
);
  localparam int unsigned RW = cw(VSIZE);
  localparam int unsigned PW = cw(REPEATS);

  logic [PW-1:0] rep;
  logic [RW-1:0] vidx;
  logic [RW-1:0] idx_next;
  logic          rep_last;
  half_e         half;

  assign rep_last = (rep == PW'(REPEATS - 1));
  assign idx_next = vidx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep         <= '0;
      vidx        <= '0;
      rd_row      <= '0;
      half        <= HALF_TOP;
      frame_valid <= 1'b0;
      proc_ready  <= 1'b0;
    end else begin
      proc_ready <= 1'b0;
      if (window_open) frame_valid <= 1'b1;
      if (burst_done) begin
        if (!rep_last) begin
          rep <= rep + 1'b1;
        end else begin
          rep <= '0;
          if (idx_next == RW'(VSIZE - 1)) begin
            vidx        <= '0;
            rd_row      <= '0;
            frame_valid <= 1'b0;
            half        <= HALF_TOP;
            proc_ready  <= 1'b1;
          end else if (idx_next == RW'(VSIZE/2 - 1)) begin
            vidx       <= idx_next;
            rd_row     <= RW'(VSIZE/2);
            half       <= HALF_BOT;
            proc_ready <= 1'b1;
          end else begin
            vidx   <= idx_next;
            rd_row <= rd_row + 1'b1;
          end
        end
      end
    end
  end

  assign top_drawing = (half == HALF_TOP);
  assign bot_drawing = (half == HALF_BOT);

  AST_READY_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    proc_ready |=> !proc_ready); // R10
  AST_HALF_SWAP_SIGNALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(top_drawing) |-> proc_ready); // R7
  AST_ROW_MOVES_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_row) |-> $past(burst_done)); // R6

endmodule

// File: rtl/tri_line_scanout.sv
module tri_line_scanout import tls_pkg::*; #(
  parameter int unsigned LINE_TICKS  = 4096,
  parameter int unsigned HSYNC_TICKS = 288,
  parameter int unsigned BURST_START = 800,
  parameter int unsigned FRAME_LINES = 625,
  parameter int unsigned VSYNC_LINES = 2,
  parameter int unsigned ACTIVE_LINE = 24,
  parameter int unsigned HSIZE       = 50,
  parameter int unsigned VSIZE       = 200,
  parameter int unsigned BYTE_TICKS  = 8,
  parameter int unsigned REPEATS     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    rd_en,
  output logic [cw(VSIZE)-1:0]    rd_row,
  output logic [cw(HSIZE+2)-1:0]  rd_byte,
  input  logic [7:0]              rd_data,
  output logic                    hsync,
  output logic                    vsync,
  output logic [7:0]              pixel,
  output logic                    top_drawing,
  output logic                    bot_drawing,
  output logic                    proc_ready
);
  logic burst_slot, window_open, frame_valid, burst_done;

  tls_timing #(
    .LINE_TICKS (LINE_TICKS),
    .HSYNC_TICKS(HSYNC_TICKS),
    .BURST_START(BURST_START),
    .FRAME_LINES(FRAME_LINES),
    .VSYNC_LINES(VSYNC_LINES),
    .ACTIVE_LINE(ACTIVE_LINE)
  ) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync      (hsync),
    .vsync      (vsync),
    .burst_slot (burst_slot),
    .window_open(window_open)
  );

  tls_burst #(
    .HSIZE     (HSIZE),
    .BYTE_TICKS(BYTE_TICKS)
  ) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_slot (burst_slot),
    .frame_valid(frame_valid),
    .rd_data    (rd_data),
    .rd_en      (rd_en),
    .rd_byte    (rd_byte),
    .pixel      (pixel),
    .burst_done (burst_done)
  );

  tls_rows #(
    .VSIZE  (VSIZE),
    .REPEATS(REPEATS)
  ) u_rows (
    .clk        (clk),
    .rst_n      (rst_n),
    .window_open(window_open),
    .burst_done (burst_done),
    .frame_valid(frame_valid),
    .rd_row     (rd_row),
    .top_drawing(top_drawing),
    .bot_drawing(bot_drawing),
    .proc_ready (proc_ready)
  );

endmodule

// File: tb/tri_line_scanout_test.sv
`timescale 1ns/1ps
module tri_line_scanout_test;
  localparam int L    = 64;
  localparam int HS   = 6;
  localparam int BS   = 10;
  localparam int F    = 40;
  localparam int VS   = 2;
  localparam int AL   = 5;
  localparam int HSZ  = 6;
  localparam int VSZ  = 8;
  localparam int BT   = 4;
  localparam int REP  = 3;
  localparam int NB   = HSZ + 2;
  localparam int RWD  = $clog2(VSZ);
  localparam int BWD  = $clog2(NB);
  localparam int FRAMES = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en;
  logic [RWD-1:0] rd_row;
  logic [BWD-1:0] rd_byte;
  logic [7:0] rd_data = 8'h00;
  logic hsync, vsync, top_drawing, bot_drawing, proc_ready;
  logic [7:0] pixel;

  always #2.5 clk = ~clk;

  tri_line_scanout #(
    .LINE_TICKS(L), .HSYNC_TICKS(HS), .BURST_START(BS), .FRAME_LINES(F),
    .VSYNC_LINES(VS), .ACTIVE_LINE(AL), .HSIZE(HSZ), .VSIZE(VSZ),
    .BYTE_TICKS(BT), .REPEATS(REP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_row(rd_row), .rd_byte(rd_byte),
    .rd_data(rd_data), .hsync(hsync), .vsync(vsync), .pixel(pixel),
    .top_drawing(top_drawing), .bot_drawing(bot_drawing), .proc_ready(proc_ready)
  );

  function automatic logic [7:0] memf(input int r, input int b);
    if (b == 0 || b == NB - 1) return 8'h00;
    return 8'(128 + r * 8 + b);
  endfunction

  // Buffer model: one cycle read latency.
  always @(posedge clk) if (rd_en) rd_data <= memf(int'(rd_row), int'(rd_byte));

  int total = 0;
  int failed = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp, input int cyc);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Reference model state
  int c = 0;
  int m_tb = -1;
  int m_brow = 0;
  int m_idx = 0;
  int m_rep = 0;
  int m_ptr = 0;
  bit m_valid = 0;
  bit m_top = 1;
  int obs_bursts = 0;
  int obs_ready = 0;
  int obs_mid = 0;

  task automatic step();
    int h, v, exp_rd, exp_byte, exp_pix, exp_ready;
    h = c % L;
    v = (c / L) % F;
    exp_ready = 0;
    if (m_tb >= 0 && c == m_tb + BT * NB + 1) begin
      if (m_rep < REP - 1) m_rep++;
      else begin
        m_rep = 0;
        m_idx++;
        if (m_idx == VSZ - 1) begin
          m_idx = 0; m_ptr = 0; m_valid = 0; m_top = 1; exp_ready = 1;
        end else if (m_idx == VSZ/2 - 1) begin
          m_ptr = VSZ/2; m_top = 0; exp_ready = 1;
        end else m_ptr++;
      end
    end
    if (h == 0 && v == AL) m_valid = 1;
    if (h == BS && m_valid && !(m_tb >= 0 && c <= m_tb + BT * NB)) begin
      m_tb = c; m_brow = m_ptr;
    end
    exp_rd = 0; exp_byte = 0;
    if (m_tb >= 0 && c >= m_tb && c < m_tb + BT * NB && ((c - m_tb) % BT) == 0) begin
      exp_rd = 1; exp_byte = (c - m_tb) / BT;
    end
    exp_pix = 0;
    if (m_tb >= 0 && c >= m_tb + 2 && c < m_tb + 2 + BT * NB)
      exp_pix = int'(memf(m_brow, (c - m_tb - 2) / BT));

    chk("R1 hsync", int'(hsync), (h < HS) ? 1 : 0, c);
    chk("R2 vsync", int'(vsync), (v < VS) ? 1 : 0, c);
    chk("R3 R4 rd_en", int'(rd_en), exp_rd, c);
    if (exp_rd == 1) begin
      chk("R4 rd_byte", int'(rd_byte), exp_byte, c);
      chk("R6 rd_row", int'(rd_row), m_brow, c);
    end
    chk("R5 pixel", int'(pixel), exp_pix, c);
    chk("R7 R8 top_drawing", int'(top_drawing), int'(m_top), c);
    chk("R7 R8 bot_drawing", int'(bot_drawing), m_top ? 0 : 1, c);
    chk("R10 proc_ready", int'(proc_ready), exp_ready, c);

    if (rd_en && rd_byte == '0) obs_bursts++;
    if (rd_en && int'(rd_row) == VSZ/2 - 1) obs_mid++;
    if (proc_ready) obs_ready++;
    if ((c % (L * F)) == L * F - 1) begin
      chk("R8 bursts per frame", obs_bursts, REP * (VSZ - 1), c);
      chk("R10 ready pulses per frame", obs_ready, 2, c);
      chk("R7 skipped row never read", obs_mid, 0, c);
      obs_bursts = 0; obs_ready = 0; obs_mid = 0;
    end
    c++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset hsync", int'(hsync), 1, -1);
    chk("R9 reset vsync", int'(vsync), 1, -1);
    chk("R9 reset pixel", int'(pixel), 0, -1);
    chk("R9 reset rd_en", int'(rd_en), 0, -1);
    chk("R9 reset top", int'(top_drawing), 1, -1);
    chk("R9 reset bot", int'(bot_drawing), 0, -1);
    chk("R9 reset ready", int'(proc_ready), 0, -1);
    rst_n = 1'b1;
    for (int i = 0; i < FRAMES * L * F; i++) begin
      step();
      @(negedge clk);
    end
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule